// File: doc/BRIEF.md
# Byte-Sequenced Two-Wire Bus Master

This block is the controller side of a two-wire open-drain serial bus (I2C). It never drives a line high: each wire has an output enable, and asserting it pulls the wire low. Deasserting it lets the external pull-up raise the wire. A host steps the bus through a transfer one command at a time. The commands are: a start condition, a byte write, a byte read that ends in an acknowledge, a byte read that ends in a not-acknowledge, and a stop condition. The host then reads the received byte and the acknowledge level that the bus returned.

Every bit time is split into four equal quarter-phases. The clock wire is low in the first and last quarters and released in the two middle quarters. The data wire changes only at the start of the first quarter, and it is sampled at the centre of the released clock time. A quarter lasts `QTR_STD` system clocks in standard mode and `QTR_FAST` system clocks in fast mode. The mode is taken from `fast_mode` when each command is accepted, so it can be changed between commands. The defaults, for a 100 MHz system clock, give 100 kbit/s and a little under 400 kbit/s. A byte transfer is followed by a ninth clock for the acknowledge. After a byte or a start, both wires are held low so that the next byte, a repeated start or a stop can follow.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, and after a stop has completed, `scl_oe` and `sda_oe` are both 0 (both wires released) and `busy` is 0.
- R2: Command code 1 (start) first releases the data wire while the clock is low, then releases the clock. It then pulls the data wire low while the clock is released, and only after that pulls the clock low. It works from the idle bus and from a parked bus (repeated start).
- R3: Command code 5 (stop) first releases the clock while the data wire is held low, and only then releases the data wire. This leaves both wires high.
- R4: Command code 2 (write) sends `cmd_data` on the data wire most significant bit first. The data wire changes only while the clock wire is low, so a byte transfer produces no start or stop condition on the bus.
- R5: On the ninth clock of a write, the master releases the data wire, so the level seen on the bus is the receiver's answer alone.
- R6: A completed start, write or read leaves both `scl_oe` and `sda_oe` at 1 (both wires held low).
- R7: After a write, `ack_received` is 1 when the data wire read low on the ninth clock and 0 when it read high.
- R8: Command codes 3 and 4 read a byte most significant bit first into `rd_data`. On the ninth clock the master pulls the data wire low for code 3 and releases it for code 4.
- R9: With the mode taken from `fast_mode` at acceptance, a start or stop lasts 4 quarters and a byte lasts 36 quarters. A quarter is `QTR_FAST` cycles when fast and `QTR_STD` cycles otherwise. `done` is a one-cycle pulse in the cycle that `busy` falls.
- R10: A command offered while `busy` is 1 is ignored, and so is any code of 0, 6 or 7. Neither changes the wires or the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_code | input | 3 | 1 start, 2 write, 3 read+ack, 4 read+nack, 5 stop |
| cmd_data | input | 8 | Byte to write |
| fast_mode | input | 1 | Quarter length select, latched per command |
| sda_in | input | 1 | Level of the data wire |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse when a command ends |
| rd_data | output | 8 | Last byte read |
| ack_received | output | 1 | Data wire read low on the ninth clock of the last write |
| scl_oe | output | 1 | Pull the clock wire low |
| sda_oe | output | 1 | Pull the data wire low |

## Verification
The bench builds the block with `QTR_STD` = 5 and `QTR_FAST` = 3, so a byte takes only 180 or 108 cycles. That makes it cheap to write every one of the 256 byte values and to read every one of them back. The writes alternate the acknowledge answer and the speed mode, and the reads alternate between codes 3 and 4. A behavioural bus target in the bench decodes start and stop conditions and the sampled bits from the wired-AND levels of the two wires. Each exact transfer length is checked against the quarter count of the requirements.

// File: rtl/i2c_master_pkg.sv
package i2c_master_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    CMD_NONE      = 3'd0,
    CMD_START     = 3'd1,
    CMD_WRITE     = 3'd2,
    CMD_READ_ACK  = 3'd3,
    CMD_READ_NACK = 3'd4,
    CMD_STOP      = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_BYTE,
    ST_STOP
  } state_e;

endpackage

// File: rtl/i2c_quarter_gen.sv
module i2c_quarter_gen #(
  parameter int QTR_STD  = 250,
  parameter int QTR_FAST = 63
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  output logic tick
);

  localparam int QMAX = (QTR_STD > QTR_FAST) ? QTR_STD : QTR_FAST;
  localparam int CW   = $clog2(QMAX + 1);
  localparam logic [CW-1:0] LIM_STD  = CW'(QTR_STD - 1);
  localparam logic [CW-1:0] LIM_FAST = CW'(QTR_FAST - 1);

  logic [CW-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim   = fast ? LIM_FAST : LIM_STD;
    tick  = run && (cnt_q == lim);
    cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/i2c_byte_shift.sv
module i2c_byte_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         in_bit,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (load)       q_d = load_val;
    else if (shift) q_d = {q[W-2:0], in_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_master_pkg::*;
#(
  parameter int QTR_STD  = 250,
  parameter int QTR_FAST = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_code,
  input  logic [BYTE_W-1:0] cmd_data,
  input  logic              fast_mode,
  input  logic              sda_in,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rd_data,
  output logic              ack_received,
  output logic              scl_oe,
  output logic              sda_oe
);

  localparam int BW = $clog2(BYTE_W + 1);
  localparam logic [BW-1:0] ACK_BIT = BW'(BYTE_W);

  state_e            state_q, state_d;
  logic [1:0]        phase_q, phase_d;
  logic [BW-1:0]     bit_q, bit_d;
  cmd_e              cmd_q, cmd_n;
  logic              fast_q;
  logic              scl_q, sda_q, scl_d, sda_d, upd;
  logic              done_q, done_d;
  logic              ack_q, ack_d;
  logic [BYTE_W-1:0] rd_q, rd_d;
  logic              sda_s1, sda_s2;
  logic              tick, accept, code_ok, shift, tx_bit;
  logic [BYTE_W-1:0] sh_q;

  i2c_quarter_gen #(.QTR_STD(QTR_STD), .QTR_FAST(QTR_FAST)) u_qgen (
    .clk(clk), .rst_n(rst_n), .run(state_q != ST_IDLE), .fast(fast_q), .tick(tick)
  );

  i2c_byte_shift #(.W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(cmd_data),
    .shift(shift), .in_bit(sda_s2), .q(sh_q)
  );

  assign code_ok = (cmd_code >= 3'd1) && (cmd_code <= 3'd5);
  assign accept  = cmd_valid && code_ok && (state_q == ST_IDLE);
  assign cmd_n   = accept ? cmd_e'(cmd_code) : cmd_q;
  assign tx_bit  = accept ? cmd_data[BYTE_W-1] : sh_q[BYTE_W-1];

  // sequencing: phases, bit index, sampling
  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    bit_d   = bit_q;
    done_d  = 1'b0;
    ack_d   = ack_q;
    rd_d    = rd_q;
    shift   = 1'b0;
    upd     = 1'b0;
    if (accept) begin
      upd     = 1'b1;
      phase_d = 2'd0;
      bit_d   = '0;
      if (cmd_n == CMD_START)     state_d = ST_START;
      else if (cmd_n == CMD_STOP) state_d = ST_STOP;
      else                        state_d = ST_BYTE;
    end else if (state_q != ST_IDLE && tick) begin
      upd = 1'b1;
      if (phase_q != 2'd3) begin
        phase_d = phase_q + 2'd1;
      end else begin
        phase_d = 2'd0;
        if (state_q == ST_BYTE && bit_q != ACK_BIT) begin
          bit_d = bit_q + 1'b1;
        end else begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          if (cmd_q == CMD_READ_ACK || cmd_q == CMD_READ_NACK) rd_d = sh_q;
        end
      end
      // mid-high sample point
      if (state_q == ST_BYTE && phase_q == 2'd1) begin
        if (bit_q != ACK_BIT)        shift = 1'b1;
        else if (cmd_q == CMD_WRITE) ack_d = !sda_s2;
      end
    end
  end

  // wire levels for the phase being entered
  always_comb begin
    scl_d = scl_q;
    sda_d = sda_q;
    unique case (state_d)
      ST_IDLE: begin
        if (done_d) begin
          scl_d = (cmd_q != CMD_STOP);
          sda_d = (cmd_q != CMD_STOP);
        end
      end
      ST_START: begin
        unique case (phase_d)
          2'd0: sda_d = 1'b0;
          2'd1: begin scl_d = 1'b0; sda_d = 1'b0; end
          2'd2: begin scl_d = 1'b0; sda_d = 1'b1; end
          2'd3: begin scl_d = 1'b1; sda_d = 1'b1; end
        endcase
      end
      ST_STOP: begin
        unique case (phase_d)
          2'd0: begin scl_d = 1'b1; sda_d = 1'b1; end
          2'd1: begin scl_d = 1'b0; sda_d = 1'b1; end
          2'd2: begin scl_d = 1'b0; sda_d = 1'b1; end
          2'd3: begin scl_d = 1'b0; sda_d = 1'b0; end
        endcase
      end
      ST_BYTE: begin
        scl_d = (phase_d == 2'd0) || (phase_d == 2'd3);
        if (phase_d == 2'd0) begin
          if (bit_d != ACK_BIT) sda_d = (cmd_n == CMD_WRITE) && !tx_bit;
          else                  sda_d = (cmd_n == CMD_READ_ACK);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= 2'd0;
      bit_q   <= '0;
      cmd_q   <= CMD_NONE;
      fast_q  <= 1'b0;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
      done_q  <= 1'b0;
      ack_q   <= 1'b0;
      rd_q    <= '0;
      sda_s1  <= 1'b1;
      sda_s2  <= 1'b1;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      bit_q   <= bit_d;
      done_q  <= done_d;
      ack_q   <= ack_d;
      rd_q    <= rd_d;
      sda_s1  <= sda_in;
      sda_s2  <= sda_s1;
      if (accept) begin
        cmd_q  <= cmd_n;
        fast_q <= fast_mode;
      end
      if (upd) begin
        scl_q <= scl_d;
        sda_q <= sda_d;
      end
    end
  end

  assign busy         = (state_q != ST_IDLE);
  assign done         = done_q;
  assign rd_data      = rd_q;
  assign ack_received = ack_q;
  assign scl_oe       = scl_q;
  assign sda_oe       = sda_q;

endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk
  import i2c_master_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_code,
  input logic       busy,
  input logic       done,
  input logic       scl_oe,
  input logic       sda_oe,
  input state_e     st,
  input cmd_e       cmd
);

  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !scl_oe) |-> !sda_oe);

  p_start_clock_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_START && $rose(scl_oe)) |-> sda_oe);

  p_start_data_up_low_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_START && $rose(sda_oe)) |-> !scl_oe);

  p_stop_clock_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STOP && $fell(sda_oe)) |-> !scl_oe);

  p_data_steady_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BYTE && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));

  p_park_after_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (cmd == CMD_WRITE || cmd == CMD_READ_ACK || cmd == CMD_READ_NACK))
      |-> (scl_oe && sda_oe));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_with_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_bad_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && (cmd_code == 3'd0 || cmd_code > 3'd5)) |=> !busy);

endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .busy(busy), .done(done), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .st(state_q), .cmd(cmd_q)
);

// File: tb/i2c_byte_master_tb.sv
`timescale 1ns/1ps
module i2c_byte_master_tb;

  localparam int QS = 5;
  localparam int QF = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_code = 3'd0;
  logic [7:0] cmd_data = 8'd0;
  logic       fast_mode = 1'b0;
  logic       busy, done, ack_received, scl_oe, sda_oe;
  logic [7:0] rd_data;
  logic       scl_w, sda_w, s_drive;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // bus target model state
  int         s_mode = 0;      // 0 none, 1 receive, 2 transmit
  logic [7:0] s_tx = 8'd0;
  logic       s_ack_en = 1'b0;
  int         arm_req = 0;
  int         arm_seen = 0;
  int         s_bit = 15;
  logic [7:0] s_rx = 8'd0;
  logic       s_nine = 1'b0;
  int         starts = 0;
  int         stops = 0;
  logic       p_scl = 1'b1;
  logic       p_sda = 1'b1;

  always #5 clk = ~clk;

  i2c_byte_master #(.QTR_STD(QS), .QTR_FAST(QF)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_data(cmd_data), .fast_mode(fast_mode), .sda_in(sda_w),
    .busy(busy), .done(done), .rd_data(rd_data), .ack_received(ack_received),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  assign scl_w   = ~scl_oe;
  assign sda_w   = ~(sda_oe | s_drive);
  assign s_drive = (s_mode == 1) ? (s_bit == 8 && s_ack_en) :
                   (s_mode == 2) ? (s_bit < 8 && !s_tx[3'(7 - s_bit)]) : 1'b0;

  always @(negedge clk) begin
    if (arm_req != arm_seen) begin
      arm_seen = arm_req;
      s_bit    = 0;
    end else begin
      if (p_scl && scl_w && p_sda && !sda_w) starts++;
      if (p_scl && scl_w && !p_sda && sda_w) stops++;
      if (!p_scl && scl_w) begin
        if (s_bit < 8) s_rx = {s_rx[6:0], sda_w};
        else           s_nine = sda_w;
      end
      if (p_scl && !scl_w && s_bit < 15) s_bit++;
    end
    p_scl = scl_w;
    p_sda = sda_w;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [2:0] code, input logic [7:0] data,
                         input logic fast, output int cyc);
    @(negedge clk);
    cmd_code  = code;
    cmd_data  = data;
    fast_mode = fast;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 10000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic arm_target(input int mode);
    @(negedge clk);
    s_mode = mode;
    arm_req++;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R9 actual %0h expected %0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int cyc, st0, sp0;
    logic oe_scl, oe_sda;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!scl_oe && !sda_oe, "R1 reset lines", {scl_oe, sda_oe}, 0);
    check(!busy, "R1 reset busy", busy, 0);

    // R2: start from idle bus
    st0 = starts; sp0 = stops;
    arm_target(0);
    run_cmd(3'd1, 8'h00, 1'b0, cyc);
    check(starts == st0 + 1, "R2 start from idle", starts, st0 + 1);
    check(stops == sp0, "R2 no stop at start", stops, sp0);
    check(cyc == 4 * QS, "R9 start length", cyc, 4 * QS);
    check(scl_oe && sda_oe, "R6 park after start", {scl_oe, sda_oe}, 3);

    // R4 R5 R7 R9: all byte values written
    st0 = starts; sp0 = stops;
    for (int v = 0; v < 256; v++) begin
      s_ack_en = ~v[0];
      arm_target(1);
      run_cmd(3'd2, 8'(v), v[1], cyc);
      check(s_rx == 8'(v), "R4 write byte msb first", s_rx, v);
      check(s_nine == v[0], "R5 ninth clock released", s_nine, v[0]);
      check(ack_received == ~v[0], "R7 ack status", ack_received, ~v[0]);
      check(cyc == 36 * (v[1] ? QF : QS), "R9 byte length", cyc, 36 * (v[1] ? QF : QS));
      check(scl_oe && sda_oe, "R6 park after write", {scl_oe, sda_oe}, 3);
    end
    check(starts == st0 && stops == sp0, "R4 no condition during writes",
          starts + stops, st0 + sp0);

    // R2: repeated start from parked bus
    st0 = starts; sp0 = stops;
    arm_target(0);
    run_cmd(3'd1, 8'h00, 1'b1, cyc);
    check(starts == st0 + 1, "R2 repeated start", starts, st0 + 1);
    check(stops == sp0, "R2 repeated start no stop", stops, sp0);
    check(cyc == 4 * QF, "R9 fast start length", cyc, 4 * QF);

    // R8: all byte values read, ack and nack alternating
    st0 = starts; sp0 = stops;
    for (int v = 0; v < 256; v++) begin
      s_tx = 8'(v);
      arm_target(2);
      run_cmd(v[0] ? 3'd4 : 3'd3, 8'h00, v[2], cyc);
      check(rd_data == 8'(v), "R8 read byte", rd_data, v);
      check(s_nine == v[0], "R8 master ack level", s_nine, v[0]);
      check(cyc == 36 * (v[2] ? QF : QS), "R9 read length", cyc, 36 * (v[2] ? QF : QS));
      check(scl_oe && sda_oe, "R6 park after read", {scl_oe, sda_oe}, 3);
    end
    check(starts == st0 && stops == sp0, "R4 no condition during reads",
          starts + stops, st0 + sp0);

    // R10: command offered while busy is ignored
    st0 = starts; sp0 = stops;
    s_ack_en = 1'b1;
    arm_target(1);
    @(negedge clk);
    cmd_code = 3'd2; cmd_data = 8'hA5; fast_mode = 1'b0; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_code = 3'd5; cmd_data = 8'h3C;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 10000) begin
      @(negedge clk);
      cyc++;
    end
    repeat (10) @(negedge clk);
    check(!busy, "R10 busy offer dropped", busy, 0);
    check(stops == sp0, "R10 no stop from busy offer", stops, sp0);
    check(s_rx == 8'hA5, "R10 write unaffected", s_rx, 8'hA5);
    check(scl_oe && sda_oe, "R10 still parked", {scl_oe, sda_oe}, 3);

    // R10: invalid codes ignored
    for (int c = 0; c < 3; c++) begin
      oe_scl = scl_oe; oe_sda = sda_oe;
      @(negedge clk);
      cmd_code  = (c == 0) ? 3'd0 : (c == 1) ? 3'd6 : 3'd7;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (2 * QS) @(negedge clk);
      check(!busy, "R10 invalid code busy", busy, 0);
      check(scl_oe == oe_scl && sda_oe == oe_sda, "R10 invalid code lines",
            {scl_oe, sda_oe}, {oe_scl, oe_sda});
    end

    // R3: stop from parked bus
    st0 = starts; sp0 = stops;
    arm_target(0);
    run_cmd(3'd5, 8'h00, 1'b0, cyc);
    check(stops == sp0 + 1, "R3 stop condition", stops, sp0 + 1);
    check(starts == st0, "R3 no start at stop", starts, st0);
    check(cyc == 4 * QS, "R9 stop length", cyc, 4 * QS);
    check(scl_w && sda_w, "R3 lines high after stop", {scl_w, sda_w}, 3);
    check(!scl_oe && !sda_oe && !busy, "R1 idle after stop", {busy, scl_oe, sda_oe}, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule